// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This block decides when a clock-distribution chip is in reset, where its configuration comes from after that reset, and when its clock outputs may toggle again. Four things can start a reset: a one-cycle power-on pulse from the supply monitor, an active-low hard-reset pin, a soft-reset pair of control bits written over the serial port, and a reload bit asking for the non-volatile image. A strap pin chooses between the stored image and the built-in defaults. For every reset source, the block holds the outputs in sync, issues a restore request and waits for its acknowledge. It then counts a settling delay on a divided reference clock before enabling the outputs. Which delay it uses depends on the reset source and on the restore source.

A separate active-low power-down input gates the outputs off without touching configuration. The sequencer keeps running while the chip is powered down, so control writes made in that time still take effect. When power-down is released, the outputs return with no restore.

Top module: `rst_pd_seq`

## Requirements
- R1: A `por_pulse` raises `restore_req` with `restore_src` equal to `strap_nvm` (1 = stored image, 0 = defaults). After the acknowledge, `out_en` rises exactly POR_TICKS*PRE_DIV clock cycles later.
- R2: Pulling `rst_pin_n` low drops `out_en` and raises `sync_hold` at once, with no clock edge needed. It also clears both soft-reset bits and the reload bit.
- R3: After `rst_pin_n` is released, a restore request follows with `restore_src` equal to `strap_nvm`. `out_en` then rises SHORT_TICKS*PRE_DIV cycles after the acknowledge when the strap is 0, and LONG_TICKS*PRE_DIV cycles after it when the strap is 1.
- R4: A write that leaves both `rst_bits` set (bit 0 and bit 1 of `ctl_rst_bits`) starts a soft reset. `out_en` stays low while the bits are set. The restore that follows uses the same source and delay rules as R3.
- R5: While both soft-reset bits are set, the block stays in reset and issues no restore. The first `sclk_tick` clears both bits, and only after that does the restore request appear.
- R6: A write that sets only one of the two soft-reset bits stores it but causes no reset: `out_en` stays high and no restore is requested.
- R7: `reload_wr` sets `reload_bit` only when `strap_nvm` is 1. With the strap at 0 the write is ignored. A set reload bit holds reset, clears on the next `sclk_tick`, and is followed by a restore with `restore_src` = 1 and a LONG_TICKS*PRE_DIV delay.
- R8: While `pd_n` is low, `out_en` is 0 and `pwr_dn` is 1 (two-cycle synchronizer) and no restore is issued. Control writes made in that time still take effect. Releasing `pd_n` restores `out_en` without a restore request.
- R9: A new reset source that arrives during a settling count restarts the sequence. `out_en` stays low throughout, and the new source's delay is counted in full.
- R10: `sync_hold` is high in every state except running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_pin_n | input | 1 | Asynchronous hard reset, active low |
| por_pulse | input | 1 | Power-on reset pulse, synchronous |
| strap_nvm | input | 1 | Restore source strap: 1 stored image, 0 defaults |
| pd_n | input | 1 | Power-down, active low |
| sclk_tick | input | 1 | One-cycle strobe per serial clock |
| ctl_wr | input | 1 | Write strobe for the soft-reset bits |
| ctl_rst_bits | input | 2 | Soft-reset bit values written |
| reload_wr | input | 1 | Write of 1 to the reload bit |
| restore_ack | input | 1 | Restore complete handshake |
| restore_req | output | 1 | Restore request, held until acknowledged |
| restore_src | output | 1 | Restore source: 1 stored image, 0 defaults |
| sync_hold | output | 1 | Outputs held in sync |
| out_en | output | 1 | Clock outputs may toggle |
| pwr_dn | output | 1 | Chip powered down |
| rst_bits | output | 2 | Current soft-reset bits |
| reload_bit | output | 1 | Current reload bit |

## Verification
The hardest case to reach is a second reset that lands in the middle of a settling count. To get there, the bench performs a hard reset and lets its restore be acknowledged. It waits a few cycles so the count is in progress, then fires a power-on pulse and measures the full power-on delay from the new acknowledge. Power-down is also awkward, because the sequencer's progress is hidden while outputs are gated. The bench writes a reload during power-down, waits out the long delay, and then checks that `out_en` returns on release with no restore request.

// File: rtl/rst_pd_seq.sv
module rst_pd_seq #(
  parameter int PRE_DIV     = 4,
  parameter int POR_TICKS   = 20,
  parameter int LONG_TICKS  = 10,
  parameter int SHORT_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       por_pulse,
  input  logic       strap_nvm,
  input  logic       pd_n,
  input  logic       sclk_tick,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_rst_bits,
  input  logic       reload_wr,
  input  logic       restore_ack,
  output logic       restore_req,
  output logic       restore_src,
  output logic       sync_hold,
  output logic       out_en,
  output logic       pwr_dn,
  output logic [1:0] rst_bits,
  output logic       reload_bit
);
  localparam int MAXT = (POR_TICKS > LONG_TICKS) ?
                        ((POR_TICKS > SHORT_TICKS) ? POR_TICKS : SHORT_TICKS) :
                        ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS);
  localparam int CW = $clog2(MAXT + 1);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  typedef enum logic [1:0] {S_RST, S_REQ, S_WAIT, S_RUN} st_t;
  typedef enum logic [1:0] {K_POR, K_PIN, K_SOFT, K_LOAD} kind_t;

  st_t   state;
  kind_t kind;
  logic [1:0]    rsync, pdsync;
  logic [CW-1:0] cnt, load;
  logic [PW-1:0] pre;
  logic          soft_act, rst_any, pin_rel, pd_on;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      rsync  <= '0;
      pdsync <= '0;
    end else begin
      rsync  <= {rsync[0], 1'b1};
      pdsync <= {pdsync[0], pd_n};
    end

  assign pin_rel  = rsync[1];
  assign pd_on    = pdsync[1];
  assign soft_act = &rst_bits;
  assign rst_any  = por_pulse | ~pin_rel | soft_act | reload_bit;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n)                rst_bits <= '0;
    else if (por_pulse)            rst_bits <= '0;
    else if (soft_act && sclk_tick) rst_bits <= '0;
    else if (ctl_wr)               rst_bits <= ctl_rst_bits;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n)                  reload_bit <= 1'b0;
    else if (por_pulse)              reload_bit <= 1'b0;
    else if (reload_bit && sclk_tick) reload_bit <= 1'b0;
    else if (reload_wr && strap_nvm) reload_bit <= 1'b1;

  assign load = (kind == K_POR) ? CW'(POR_TICKS) :
                restore_src     ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      state       <= S_RST;
      kind        <= K_PIN;
      restore_src <= 1'b0;
      cnt         <= '0;
      pre         <= '0;
    end else if (rst_any) begin
      state <= S_RST;
      if (por_pulse)     kind <= K_POR;
      else if (!pin_rel) kind <= K_PIN;
      else if (soft_act) kind <= K_SOFT;
      else               kind <= K_LOAD;
    end else begin
      case (state)
        S_RST: begin
          state       <= S_REQ;
          restore_src <= (kind == K_LOAD) ? 1'b1 : strap_nvm;
        end
        S_REQ:
          if (restore_ack) begin
            state <= S_WAIT;
            cnt   <= load;
            pre   <= '0;
          end
        S_WAIT:
          if (pre == PW'(PRE_DIV - 1)) begin
            pre <= '0;
            if (cnt <= CW'(1)) state <= S_RUN;
            else               cnt <= cnt - CW'(1);
          end else begin
            pre <= pre + PW'(1);
          end
        default: state <= S_RUN;
      endcase
    end

  assign restore_req = (state == S_REQ);
  assign sync_hold   = (state != S_RUN);
  assign out_en      = (state == S_RUN) && pd_on;
  assign pwr_dn      = ~pd_on;

  // R1
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    por_pulse |=> sync_hold && !out_en);
  // R4
  soft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (&rst_bits) |=> !out_en);
  // R5
  soft_stay_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ((&rst_bits) && !sclk_tick && !por_pulse) |=> (&rst_bits) && !restore_req);
  // R5
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ((&rst_bits) && sclk_tick) |=> (rst_bits == 2'b00));
  // R7
  reload_ign_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (reload_wr && !strap_nvm && !reload_bit) |=> !reload_bit);
endmodule

// File: tb/rst_pd_seq_tb.sv
module rst_pd_seq_tb;
  localparam int PRE = 4, TPOR = 20, TLONG = 10, TSHORT = 2;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0, por_pulse = 1'b0, strap_nvm = 1'b0, pd_n = 1'b1;
  logic sclk_tick = 1'b0, ctl_wr = 1'b0, reload_wr = 1'b0, restore_ack = 1'b0;
  logic [1:0] ctl_rst_bits = 2'b00;
  logic restore_req, restore_src, sync_hold, out_en, pwr_dn, reload_bit;
  logic [1:0] rst_bits;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) restore_ack <= restore_req;

  rst_pd_seq #(.PRE_DIV(PRE), .POR_TICKS(TPOR), .LONG_TICKS(TLONG), .SHORT_TICKS(TSHORT)) u_dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .por_pulse(por_pulse), .strap_nvm(strap_nvm),
    .pd_n(pd_n), .sclk_tick(sclk_tick), .ctl_wr(ctl_wr), .ctl_rst_bits(ctl_rst_bits),
    .reload_wr(reload_wr), .restore_ack(restore_ack), .restore_req(restore_req),
    .restore_src(restore_src), .sync_hold(sync_hold), .out_en(out_en), .pwr_dn(pwr_dn),
    .rst_bits(rst_bits), .reload_bit(reload_bit));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int n, output bit src);
    int w = 0;
    n = -1; src = 1'b0;
    while (!restore_req && w < 400) begin @(negedge clk); w++; end
    if (!restore_req) return;
    src = restore_src;
    while (restore_req) @(negedge clk);
    n = 0;
    while (!out_en && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic no_req(input int n, output bit seen);
    seen = 1'b0;
    repeat (n) begin @(negedge clk); if (restore_req) seen = 1'b1; end
  endtask

  task automatic t_reset_state;
    cyc(3);
    check(out_en == 0, "R2 out_en in reset", out_en, 0);
    check(sync_hold == 1, "R10 sync_hold in reset", sync_hold, 1);
    check(restore_req == 0, "R2 no req in reset", restore_req, 0);
    check(rst_bits == 0, "R2 soft bits cleared", rst_bits, 0);
  endtask

  task automatic t_por;
    int n; bit s;
    strap_nvm = 1'b1;
    rst_pin_n = 1'b1; por_pulse = 1'b1;
    cyc(3);
    por_pulse = 1'b0;
    measure(n, s);
    check(s == 1, "R1 por src follows strap", s, 1);
    check(n == TPOR*PRE, "R1 por delay", n, TPOR*PRE);
    check(sync_hold == 0, "R10 sync_hold low when running", sync_hold, 0);
  endtask

  task automatic t_pin(input bit strap);
    int n; bit s;
    strap_nvm = strap;
    #1 rst_pin_n = 1'b0;
    #1 check(out_en == 0, "R2 async drop", out_en, 0);
    check(sync_hold == 1, "R2 sync_hold async", sync_hold, 1);
    cyc(2);
    rst_pin_n = 1'b1;
    measure(n, s);
    check(s == strap, "R3 pin src", s, strap);
    check(n == (strap ? TLONG : TSHORT)*PRE, "R3 pin delay", n, (strap ? TLONG : TSHORT)*PRE);
  endtask

  task automatic t_soft;
    int n; bit s, seen;
    strap_nvm = 1'b0;
    ctl_wr = 1'b1; ctl_rst_bits = 2'b11;
    cyc(1);
    ctl_wr = 1'b0; ctl_rst_bits = 2'b00;
    check(rst_bits == 2'b11, "R4 bits stored", rst_bits, 3);
    no_req(6, seen);
    check(!seen, "R5 held in reset before tick", seen, 0);
    check(out_en == 0, "R4 out_en low during soft reset", out_en, 0);
    sclk_tick = 1'b1;
    cyc(1);
    sclk_tick = 1'b0;
    check(rst_bits == 2'b00, "R5 self clear after tick", rst_bits, 0);
    measure(n, s);
    check(s == 0, "R4 soft src", s, 0);
    check(n == TSHORT*PRE, "R4 soft delay", n, TSHORT*PRE);
  endtask

  task automatic t_single;
    bit seen;
    ctl_wr = 1'b1; ctl_rst_bits = 2'b01;
    cyc(1);
    ctl_wr = 1'b0;
    no_req(10, seen);
    check(rst_bits == 2'b01, "R6 single bit stored", rst_bits, 1);
    check(!seen, "R6 no restore", seen, 0);
    check(out_en == 1, "R6 out_en stays", out_en, 1);
    ctl_wr = 1'b1; ctl_rst_bits = 2'b00;
    cyc(1);
    ctl_wr = 1'b0;
  endtask

  task automatic t_reload;
    int n; bit s, seen;
    strap_nvm = 1'b0;
    reload_wr = 1'b1;
    cyc(1);
    reload_wr = 1'b0;
    check(reload_bit == 0, "R7 ignored with strap 0", reload_bit, 0);
    no_req(10, seen);
    check(!seen && out_en, "R7 no effect with strap 0", out_en, 1);
    strap_nvm = 1'b1;
    reload_wr = 1'b1;
    cyc(1);
    reload_wr = 1'b0;
    check(reload_bit == 1, "R7 set with strap 1", reload_bit, 1);
    cyc(3);
    check(out_en == 0, "R7 reset held", out_en, 0);
    sclk_tick = 1'b1;
    cyc(1);
    sclk_tick = 1'b0;
    check(reload_bit == 0, "R7 self clear", reload_bit, 0);
    measure(n, s);
    check(s == 1, "R7 reload src", s, 1);
    check(n == TLONG*PRE, "R7 reload delay", n, TLONG*PRE);
  endtask

  task automatic t_restart;
    int n, w; bit s, low;
    strap_nvm = 1'b0;
    #1 rst_pin_n = 1'b0;
    cyc(2);
    rst_pin_n = 1'b1;
    w = 0;
    while (!restore_req && w < 100) begin @(negedge clk); w++; end
    while (restore_req) @(negedge clk);
    cyc(4);
    check(out_en == 0, "R9 counting", out_en, 0);
    por_pulse = 1'b1;
    cyc(1);
    por_pulse = 1'b0;
    low = 1'b1;
    measure(n, s);
    check(n == TPOR*PRE, "R9 restarted full delay", n, TPOR*PRE);
    check(s == 0 && low, "R9 restart src", s, 0);
  endtask

  task automatic t_pd;
    bit seen, seen2;
    pd_n = 1'b0;
    cyc(3);
    check(out_en == 0, "R8 out_en off", out_en, 0);
    check(pwr_dn == 1, "R8 pwr_dn on", pwr_dn, 1);
    no_req(10, seen);
    check(!seen, "R8 no restore on power-down", seen, 0);
    strap_nvm = 1'b1;
    reload_wr = 1'b1;
    cyc(1);
    reload_wr = 1'b0;
    check(reload_bit == 1, "R8 write while powered down", reload_bit, 1);
    sclk_tick = 1'b1;
    cyc(1);
    sclk_tick = 1'b0;
    cyc(TLONG*PRE + 20);
    check(out_en == 0, "R8 still gated", out_en, 0);
    pd_n = 1'b1;
    no_req(3, seen2);
    check(out_en == 1 && pwr_dn == 0, "R8 resume", out_en, 1);
    check(!seen2, "R8 no restore on release", seen2, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_por();
    t_pin(1'b0);
    t_pin(1'b1);
    t_soft();
    t_single();
    t_reload();
    t_restart();
    t_pd();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule